// File: doc/BRIEF.md
# DMA Transfer Count and Autoinit Controller

This block tracks the transfer count and the memory address of one DMA channel. Every completed transfer, reported by a one-cycle strobe, steps the address up by one and the count down by one. When a strobe takes the count from one to zero, the block raises a one-cycle interrupt pulse. A 2-bit mode input then selects what the channel does next. It can keep running and let the count wrap. It can stop with a halt code. It can reload its address and count from shadow registers right away. Or it can stop with a halt code and reload only when the CPU issues a new start.

Software fills the shadow registers through a load strobe. A start command copies the shadow values into the live address and count and marks the channel as running. A 2-bit status output reports whether the channel is idle, running or halted. The movement of data is handled elsewhere.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset, addr and count are 0, status is 2'b00 (idle) and tc_irq is 0.
- R2: A load strobe latches load_addr and load_count into the shadow registers. It does not change addr, count or status.
- R3: A start command copies the shadow address into addr and the shadow count into count, and sets status to 2'b11 (run) on the next edge. A transfer strobe in the same cycle is ignored.
- R4: While status is 2'b11, each transfer strobe adds 1 to addr and subtracts 1 from count, modulo 2^32, unless R8 applies.
- R5: tc_irq is high for exactly the one cycle after the edge at which a running strobe takes count from 1 to 0. This holds in every mode, and at no other time is tc_irq high.
- R6: With mode 2'b00, the channel stays running when the count reaches zero. A further strobe wraps count from 0 to 32'hFFFFFFFF while addr keeps incrementing.
- R7: With mode 2'b01, the strobe that takes count to 0 also sets status to 2'b10 (halted). count stays 0 and addr holds the incremented value.
- R8: With mode 2'b10, the strobe that would take count to 0 instead loads addr and count from the shadow registers, and status stays 2'b11.
- R9: With mode 2'b11, reaching zero sets status to 2'b10 as in R7. A later start reloads addr and count from the shadow registers and resumes running.
- R10: Transfer strobes are ignored when status is 2'b00 or 2'b10. addr and count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Termination and autoinit mode |
| xfer_done | input | 1 | One-cycle strobe per completed transfer |
| start | input | 1 | CPU start command |
| load | input | 1 | Latch the shadow address and count |
| load_addr | input | AW | Shadow address value |
| load_count | input | CW | Shadow count value |
| addr | output | AW | Current transfer address |
| count | output | CW | Current transfer count |
| status | output | 2 | 00 idle, 11 run, 10 halted |
| tc_irq | output | 1 | Count-reached-zero interrupt pulse |

## Verification
The bound checker watches several properties on every cycle:
- a start always leads to the run code;
- a running strobe steps the address by one, except on an immediate reload;
- the count wraps from zero to all ones;
- halt modes write the halt code on the terminal strobe;
- a halted or idle channel keeps address and count steady;
- every interrupt pulse follows a strobe that took the count from one to zero.

Some behaviours depend on values loaded several cycles earlier, so only the bench scenarios can show them. These are the exact reload values in the immediate-reload and restart modes, the number of interrupts over a run, and the final address and count after a strobe sequence.

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          xfer_done,
  input  logic          start,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_count,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count,
  output logic [1:0]    status,
  output logic          tc_irq
);
  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_RUN  = 2'b11;
  localparam logic [1:0] ST_HALT = 2'b10;
  localparam logic [1:0] M_RELOAD = 2'b10;

  logic [AW-1:0] sh_addr;
  logic [CW-1:0] sh_count;

  wire step = (status == ST_RUN) && xfer_done && !start;
  wire hit  = step && (count == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_addr  <= '0;
      sh_count <= '0;
      addr     <= '0;
      count    <= '0;
      status   <= ST_IDLE;
      tc_irq   <= 1'b0;
    end else begin
      if (load) begin
        sh_addr  <= load_addr;
        sh_count <= load_count;
      end
      tc_irq <= hit;
      if (start) begin
        addr   <= sh_addr;
        count  <= sh_count;
        status <= ST_RUN;
      end else if (step) begin
        if (hit && mode == M_RELOAD) begin
          addr  <= sh_addr;
          count <= sh_count;
        end else begin
          addr  <= addr + AW'(1);
          count <= count - CW'(1);
        end
        if (hit && mode[0]) status <= ST_HALT;
      end
    end
  end
endmodule

module dma_xfer_counter_chk #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          xfer_done,
  input logic          start,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] count,
  input logic [1:0]    status,
  input logic          tc_irq
);
  wire run_step = (status == 2'b11) && xfer_done && !start;

  // R3
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> status == 2'b11);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_step && !(count == CW'(1) && mode == 2'b10) |=> addr == $past(addr) + AW'(1));

  // R6
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_step && count == '0 |=> count == '1);

  // R7
  halt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_step && count == CW'(1) && mode[0] |=> status == 2'b10 && count == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11 && !start |=> $stable(addr) && $stable(count));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_irq) |-> $past(run_step) && $past(count) == CW'(1));
endmodule

bind dma_xfer_counter dma_xfer_counter_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .xfer_done(xfer_done), .start(start),
  .addr(addr), .count(count), .status(status), .tc_irq(tc_irq));

// File: tb/dma_xfer_counter_tb.sv
`timescale 1ns/1ps
module dma_xfer_counter_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic xfer_done = 0, start = 0, load = 0;
  logic [31:0] load_addr = 0, load_count = 0;
  logic [31:0] addr, count;
  logic [1:0] status;
  logic tc_irq;
  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_xfer_counter u_dut (.clk(clk), .rst_n(rst_n), .mode(mode), .xfer_done(xfer_done),
    .start(start), .load(load), .load_addr(load_addr), .load_count(load_count),
    .addr(addr), .count(count), .status(status), .tc_irq(tc_irq));

  always @(posedge clk) if (tc_irq) irq_cnt <= irq_cnt + 1;

  // mode, shadow addr, shadow count, strobes, exp addr, exp count, exp status, exp irqs
  localparam int NV = 5;
  localparam logic [147:0] VEC [NV] = '{
    {2'b00, 32'h100, 32'd3, 8'd5, 32'h105, 32'hFFFFFFFE, 2'b11, 8'd1},
    {2'b01, 32'h200, 32'd2, 8'd5, 32'h202, 32'd0,        2'b10, 8'd1},
    {2'b10, 32'h300, 32'd2, 8'd5, 32'h301, 32'd1,        2'b11, 8'd2},
    {2'b00, 32'h500, 32'd1, 8'd1, 32'h501, 32'd0,        2'b11, 8'd1},
    {2'b11, 32'h400, 32'd3, 8'd4, 32'h403, 32'd0,        2'b10, 8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic strobe();
    xfer_done = 1; @(negedge clk); xfer_done = 0; @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr", addr, 0); chk("R1 count", count, 0);
    chk("R1 status", {30'd0, status}, 0); chk("R1 irq", {31'd0, tc_irq}, 0);
    rst_n = 1; @(negedge clk);
    strobe();
    chk("R10 idle strobe addr", addr, 0); chk("R10 idle strobe count", count, 0);
    load = 1; load_addr = 32'h77; load_count = 32'd9; @(negedge clk); load = 0;
    chk("R2 load addr", addr, 0); chk("R2 load count", count, 0);
    chk("R2 load status", {30'd0, status}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [147:0] v;
      int base;
      v = VEC[i];
      mode = v[147:146]; load = 1; load_addr = v[145:114]; load_count = v[113:82];
      @(negedge clk); load = 0; start = 1; @(negedge clk); start = 0;
      chk("R3 start addr", addr, v[145:114]); chk("R3 start count", count, v[113:82]);
      base = irq_cnt;
      for (int k = 0; k < int'(v[81:74]); k++) strobe();
      @(negedge clk);
      chk("R4/R6/R7/R8/R9 addr", addr, v[73:42]);
      chk("R4/R6/R7/R8/R9 count", count, v[41:10]);
      chk("R6/R7/R8/R9 status", {30'd0, status}, {30'd0, v[9:8]});
      chk("R5 irq count", irq_cnt - base, {24'd0, v[7:0]});
    end

    strobe();
    chk("R10 halted addr", addr, 32'h403); chk("R10 halted count", count, 0);
    start = 1; @(negedge clk); start = 0;
    chk("R9 restart addr", addr, 32'h400); chk("R9 restart count", count, 3);
    chk("R9 restart status", {30'd0, status}, 32'd3);

    start = 1; xfer_done = 1; @(negedge clk); start = 0; xfer_done = 0;
    chk("R3 start wins addr", addr, 32'h400); chk("R3 start wins count", count, 3);

    mode = 2'b00; load = 1; load_addr = 32'h10; load_count = 32'd1; @(negedge clk);
    load = 0; start = 1; @(negedge clk); start = 0;
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    chk("R5 pulse high", {31'd0, tc_irq}, 1);
    @(negedge clk);
    chk("R5 pulse low", {31'd0, tc_irq}, 0);
    strobe();
    chk("R6 wrap count", count, 32'hFFFFFFFF); chk("R6 wrap addr", addr, 32'h12);
    chk("R5 no irq on wrap", {31'd0, tc_irq}, 0);
    summary();
  end
endmodule